// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 15-bit program counter of a small microcontroller and works out its next value for every kind of control transfer. Each accepted operation carries a 3-bit mode code together with the fields that mode needs. These are a signed relative displacement, a 12-bit in-segment target, a 15-bit full target, the accumulator, or the address of an interrupt vector. Sequential flow, relative, segment-absolute and full-width jumps take effect at the next clock edge.

Two modes need program memory before the PC can move. The table jump forms a read address from the upper PC bits and the accumulator, then puts the returned byte into the low PC byte. The vector load reads two adjacent bytes, high byte first, and loads the lower 15 bits of the pair. A small sequencer issues these reads. Memory returns each byte one cycle after its request. While the sequencer waits it raises `busy`, and new operations are ignored until it is done.

Top module: `pc_next_unit`

## Requirements
- R1: While reset is active and after it is released, `pc` is 0, `busy` is 0 and `mem_req` is 0.
- R2: Mode code 0 (increment) with `op_valid` loads `pc + 1` modulo 2^15, so 0x7FFF wraps to 0x0000.
- R3: Mode code 1 (relative) treats `rel_disp` as a 6-bit two's-complement value d and loads `pc + d + 1` modulo 2^15. The reachable displacement is -31 to +32, a field of 0 gives the same result as an increment, and carries cross all 15 bits with no page limit.
- R4: Mode code 2 (segment absolute) loads `{pc[14:12], seg_target}`, so the PC stays inside its current 4K segment.
- R5: Mode code 3 (full absolute) loads `full_target` into all 15 bits.
- R6: Mode code 4 (table jump) raises `mem_req` in the accepting cycle with `mem_addr = {pc[14:8], acc}`. It holds `busy` high for the next cycle, in which the byte arrives. At the following edge it loads `{pc[14:8], byte}` and drops `busy`.
- R7: Mode code 5 (vector load) requests `vec_addr` in the accepting cycle and `vec_addr + 1` (modulo 2^15) in the next cycle. It holds `busy` for the two data cycles. After the second byte it loads bits [14:0] of `{first_byte, second_byte}`.
- R8: While `busy` is high, `op_valid` and every operation field are ignored. `pc` does not change until the sequencer itself loads it.
- R9: With `op_valid` low, or with the unused mode codes 6 and 7, `pc` holds its value and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 3 | Mode code: 0 inc, 1 rel, 2 seg abs, 3 full abs, 4 table, 5 vector |
| rel_disp | input | 6 | Signed relative field (displacement is field + 1) |
| seg_target | input | 12 | In-segment absolute target |
| full_target | input | 15 | Full-width absolute target |
| acc | input | 8 | Accumulator, low address byte for the table jump |
| vec_addr | input | 15 | Address of the vector's first (high) byte |
| mem_rdata | input | 8 | Program-memory byte, valid the cycle after a request |
| mem_req | output | 1 | Program-memory read request |
| mem_addr | output | 15 | Program-memory read address |
| busy | output | 1 | A table jump or vector load is waiting for data |
| pc | output | 15 | Current program counter |

## Verification
New operations and the sequencer's own PC load are the two functions that can fall in the same cycle. The vector load and the table jump are started while the bench keeps `op_valid` high with a full-width target during every busy cycle, including the cycle of the final byte. The result is judged by requiring `pc` to end at the value computed from the memory bytes and to stay frozen before that. The relative sweep covers every displacement code from bases next to byte, segment and top-of-space boundaries, and the vector sweep includes a vector at 0x7FFF whose second address wraps.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

  typedef enum logic [2:0] {
    MODE_INC   = 3'd0,
    MODE_REL   = 3'd1,
    MODE_SEG   = 3'd2,
    MODE_FULL  = 3'd3,
    MODE_TABLE = 3'd4,
    MODE_VEC   = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } pc_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_TABLE = 2'd1,
    SQ_VHI   = 2'd2,
    SQ_VLO   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pcnu_rst_sync.sv
module pcnu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcnu_target.sv
module pcnu_target
  import pcnu_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int SEG_W  = 12,
  parameter int DISP_W = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  pc_mode_e          mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [SEG_W-1:0]  seg_target,
  input  logic [PC_W-1:0]   full_target,
  output logic              tgt_valid,
  output logic [PC_W-1:0]   tgt_pc
);

  localparam int EXT_W = PC_W - DISP_W;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] inc_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] seg_pc;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign inc_pc   = pc + ONE;
  // field value d encodes displacement d+1: range -(2^(W-1))+1 .. 2^(W-1)
  assign rel_pc   = pc + disp_ext + ONE;

  generate
    if (SEG_W < PC_W) begin : g_seg_splice
      assign seg_pc = {pc[PC_W-1:SEG_W], seg_target};
    end else begin : g_seg_full
      assign seg_pc = seg_target[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    tgt_valid = 1'b1;
    tgt_pc    = pc;
    case (mode)
      MODE_INC:  tgt_pc = inc_pc;
      MODE_REL:  tgt_pc = rel_pc;
      MODE_SEG:  tgt_pc = seg_pc;
      MODE_FULL: tgt_pc = full_target;
      default: begin
        tgt_valid = 1'b0;
        tgt_pc    = pc;
      end
    endcase
  end

endmodule

// File: rtl/pcnu_seq.sv
module pcnu_seq
  import pcnu_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_table,
  input  logic              start_vec,
  input  logic [PC_W-1:0]   pc,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   vec_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  output logic              busy,
  output logic              load,
  output logic [PC_W-1:0]   load_pc
);

  localparam int VEC_W  = 2 * BYTE_W;
  localparam int HIGH_W = PC_W - BYTE_W;

  seq_state_e        state_q, state_d;
  logic [PC_W-1:0]   vaddr_q, vaddr_d;
  logic              vaddr_en;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              hi_en;
  logic [VEC_W-1:0]  vec_full;
  logic              unused_vec_bits;

  assign vec_full        = {hi_q, mem_rdata};
  assign unused_vec_bits = ^vec_full[VEC_W-1:PC_W];

  always_comb begin
    state_d  = state_q;
    vaddr_d  = vaddr_q;
    vaddr_en = 1'b0;
    hi_d     = hi_q;
    hi_en    = 1'b0;
    mem_req  = 1'b0;
    mem_addr = '0;
    load     = 1'b0;
    load_pc  = pc;
    case (state_q)
      SQ_IDLE: begin
        if (start_table) begin
          mem_req  = 1'b1;
          mem_addr = {pc[PC_W-1:BYTE_W], acc};
          state_d  = SQ_TABLE;
        end else if (start_vec) begin
          mem_req  = 1'b1;
          mem_addr = vec_addr;
          vaddr_en = 1'b1;
          vaddr_d  = vec_addr + PC_W'(1);
          state_d  = SQ_VHI;
        end
      end
      SQ_TABLE: begin
        load    = 1'b1;
        load_pc = {pc[PC_W-1:BYTE_W], mem_rdata};
        state_d = SQ_IDLE;
      end
      SQ_VHI: begin
        mem_req  = 1'b1;
        mem_addr = vaddr_q;
        hi_en    = 1'b1;
        hi_d     = mem_rdata;
        state_d  = SQ_VLO;
      end
      SQ_VLO: begin
        load    = 1'b1;
        load_pc = vec_full[PC_W-1:0];
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      vaddr_q <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (vaddr_en) vaddr_q <= vaddr_d;
      if (hi_en)    hi_q    <= hi_d;
    end
  end

  assign busy = (state_q != SQ_IDLE);

  // R6: a table jump holds busy for exactly the data cycle with no new request
  p_table_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && start_table) |=> (busy && !mem_req));

  // R7: second vector read follows immediately at the next address
  p_vec_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && !start_table && start_vec)
      |=> (mem_req && mem_addr == ($past(vec_addr) + PC_W'(1))));

  // R6/R7: the cycle that loads the PC ends the busy period
  p_load_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !busy);

  // HIGH_W kept for structure checks on the table address split
  initial begin
    assert (HIGH_W > 0) else $error("PC_W must exceed BYTE_W");
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int PC_W     = 15,
  parameter int SEG_W    = 12,
  parameter int DISP_W   = 6,
  parameter int BYTE_W   = 8,
  parameter int MODE_W   = 3,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [MODE_W-1:0] op_mode,
  input  logic [DISP_W-1:0] rel_disp,
  input  logic [SEG_W-1:0]  seg_target,
  input  logic [PC_W-1:0]   full_target,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   vec_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  output logic              busy,
  output logic [PC_W-1:0]   pc
);

  logic            rst_sync_n;
  pc_mode_e        mode;
  logic            accept;
  logic            tgt_valid;
  logic [PC_W-1:0] tgt_pc;
  logic            start_table;
  logic            start_vec;
  logic            seq_load;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  assign mode = pc_mode_e'(op_mode);

  pcnu_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcnu_target #(.PC_W(PC_W), .SEG_W(SEG_W), .DISP_W(DISP_W)) u_target (
    .pc          (pc_q),
    .mode        (mode),
    .disp        (rel_disp),
    .seg_target  (seg_target),
    .full_target (full_target),
    .tgt_valid   (tgt_valid),
    .tgt_pc      (tgt_pc)
  );

  assign accept      = op_valid && !busy;
  assign start_table = accept && (mode == MODE_TABLE);
  assign start_vec   = accept && (mode == MODE_VEC);

  pcnu_seq #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_table (start_table),
    .start_vec   (start_vec),
    .pc          (pc_q),
    .acc         (acc),
    .vec_addr    (vec_addr),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .load        (seq_load),
    .load_pc     (seq_pc)
  );

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if (seq_load) begin
      pc_en = 1'b1;
      pc_d  = seq_pc;
    end else if (accept && tgt_valid) begin
      pc_en = 1'b1;
      pc_d  = tgt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

  // R9: idle with nothing valid leaves the PC alone
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !op_valid) |=> (pc == $past(pc)));

  // R9: unused codes never start a read
  p_rsv_no_req_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && op_valid && op_mode[2:1] == 2'b11) |-> !mem_req);

  // R8: busy freezes the PC until the sequencer loads it
  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !seq_load) |=> $stable(pc));

  // R5: full-width target lands in every bit
  p_full_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && op_valid && op_mode == MODE_FULL) |=> (pc == $past(full_target)));

  // R4: segment bits survive a segment-absolute jump
  p_seg_keep_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && op_valid && op_mode == MODE_SEG)
      |=> (pc[PC_W-1:SEG_W] == $past(pc[PC_W-1:SEG_W])));

  // R2: increment wraps modulo 2^PC_W
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && op_valid && op_mode == MODE_INC) |=> (pc == $past(pc) + PC_W'(1)));

endmodule

// File: tb/pc_next_unit_bench.sv
`timescale 1ns/1ps
module pc_next_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_mode;
  logic [5:0]  rel_disp;
  logic [11:0] seg_target;
  logic [14:0] full_target;
  logic [7:0]  acc;
  logic [14:0] vec_addr;
  logic [7:0]  mem_rdata;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        busy;
  logic [14:0] pc;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pc_next_unit u_pc_next_unit (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_mode (op_mode),
    .rel_disp (rel_disp), .seg_target (seg_target), .full_target (full_target),
    .acc (acc), .vec_addr (vec_addr), .mem_rdata (mem_rdata),
    .mem_req (mem_req), .mem_addr (mem_addr), .busy (busy), .pc (pc)
  );

  function automatic logic [7:0] mem_f(logic [14:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd29 + 16'(a[14:8]) + 16'd7;
    return t[7:0];
  endfunction

  // program memory: one-cycle read latency
  always @(posedge clk) mem_rdata <= mem_req ? mem_f(mem_addr) : 8'h00;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // called just after a posedge; presents an op for one cycle
  task automatic do_op(logic [2:0] m, logic [5:0] d, logic [11:0] s, logic [14:0] f);
    op_valid = 1'b1; op_mode = m; rel_disp = d; seg_target = s; full_target = f;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic set_pc(logic [14:0] v);
    do_op(3'd3, 6'd0, 12'd0, v);
    chk("R5 full load", 32'(pc), 32'(v));
  endtask

  task automatic run_table(logic [14:0] base, logic [7:0] a, logic jam);
    logic [14:0] ad;
    set_pc(base);
    ad = {base[14:8], a};
    op_valid = 1'b1; op_mode = 3'd4; acc = a;
    #1;
    chk("R6 issue req", 32'(mem_req), 32'd1);
    chk("R6 issue addr", 32'(mem_addr), 32'(ad));
    @(posedge clk); #1;
    if (jam) begin op_mode = 3'd3; full_target = 15'h5A5A; end
    else op_valid = 1'b0;
    chk("R6 busy", 32'({busy, mem_req}), 32'h2);
    chk("R8 pc frozen", 32'(pc), 32'(base));
    @(posedge clk); #1;
    op_valid = 1'b0;
    chk("R6 table pc", 32'(pc), 32'({base[14:8], mem_f(ad)}));
    chk("R6 busy clear", 32'(busy), 32'd0);
  endtask

  task automatic run_vec(logic [14:0] v, logic jam);
    logic [14:0] v2;
    logic [15:0] w;
    v2 = v + 15'd1;
    w = {mem_f(v), mem_f(v2)};
    set_pc(15'h1111);
    op_valid = 1'b1; op_mode = 3'd5; vec_addr = v;
    #1;
    chk("R7 first addr", 32'({mem_req, mem_addr}), 32'({1'b1, v}));
    @(posedge clk); #1;
    if (jam) begin op_mode = 3'd3; full_target = 15'h2B2B; vec_addr = 15'h0F0F; end
    else op_valid = 1'b0;
    chk("R7 second addr", 32'({busy, mem_req, mem_addr}), 32'({2'b11, v2}));
    @(posedge clk); #1;
    chk("R7 wait", 32'({busy, mem_req}), 32'h2);
    chk("R8 pc frozen", 32'(pc), 32'h1111);
    @(posedge clk); #1;
    op_valid = 1'b0;
    chk("R7 vector pc", 32'(pc), 32'(w[14:0]));
    chk("R7 busy clear", 32'(busy), 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [14:0] bases [4];
    bases[0] = 15'h00F0; bases[1] = 15'h0FFA; bases[2] = 15'h7FF0; bases[3] = 15'h0010;
    rst_n = 1'b0; op_valid = 1'b0; op_mode = 3'd0; rel_disp = '0;
    seg_target = '0; full_target = '0; acc = '0; vec_addr = '0;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset outputs", 32'({pc, busy, mem_req}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R1 after release", 32'({pc, busy, mem_req}), 32'd0);

    // R2: increment and wrap
    set_pc(15'h7FFE);
    do_op(3'd0, 6'd0, 12'd0, 15'd0); chk("R2 inc", 32'(pc), 32'h7FFF);
    do_op(3'd0, 6'd0, 12'd0, 15'd0); chk("R2 wrap", 32'(pc), 32'h0000);

    // R3: every displacement code from several bases
    for (int b = 0; b < 4; b++) begin
      for (int d = 0; d < 64; d++) begin
        logic [14:0] e;
        int disp;
        disp = (d >= 32) ? d - 64 + 1 : d + 1;
        e = 15'(int'(bases[b]) + disp);
        set_pc(bases[b]);
        do_op(3'd1, 6'(d), 12'd0, 15'd0);
        chk("R3 relative", 32'(pc), 32'(e));
      end
    end

    // R4: segment absolute
    for (int i = 0; i < 16; i++) begin
      logic [14:0] b;
      logic [11:0] s;
      b = 15'(i * 2311 + 5);
      s = 12'(i * 273);
      set_pc(b);
      do_op(3'd2, 6'd0, s, 15'd0);
      chk("R4 segment", 32'(pc), 32'({b[14:12], s}));
    end

    // R9: unused codes and idle cycles hold
    set_pc(15'h3C3C);
    for (int m = 6; m < 8; m++) begin
      op_valid = 1'b1; op_mode = 3'(m);
      #1 chk("R9 no req", 32'(mem_req), 32'd0);
      @(posedge clk); #1;
      op_valid = 1'b0;
      chk("R9 reserved hold", 32'(pc), 32'h3C3C);
    end
    op_mode = 3'd3; full_target = 15'h0123;
    @(posedge clk); #1;
    chk("R9 invalid hold", 32'(pc), 32'h3C3C);

    // R6: table jumps
    for (int a = 0; a < 256; a += 17) run_table(15'h2A00 + 15'(a * 3), 8'(a), 1'b0);
    run_table(15'h7FFF, 8'hFF, 1'b1);

    // R7: vector loads, including wrap of the second address
    run_vec(15'h7FFE, 1'b0);
    run_vec(15'h7FFF, 1'b0);
    run_vec(15'h0000, 1'b0);
    run_vec(15'h1234, 1'b1);
    run_vec(15'h4321, 1'b1);

    finish_run();
  end

endmodule